// File: doc/BRIEF.md
# Block Address Translator

This unit maps a 32-bit data effective address to a physical address through a small set of programmable block-mapping entries. Each of the eight entries is a pair of 32-bit words, an upper (match) word and a lower (target) word, loaded through a simple write port. A lookup presents an address together with a translation-enable bit and a privilege bit. One cycle later the unit returns the physical address, a hit flag, a miss flag and the four cache-attribute bits of the winning entry.

Block mapping takes precedence over the page-table walk that follows this stage. A miss hands the untouched address to that later stage. Within the unit, the entry with the lowest index wins when several match. Each entry carries its own enable bit for supervisor accesses and another for user accesses. The protection bits of the target word are stored but do not affect the lookup.

Top module: `blk_xlat_unit`

## Requirements
- R1: With `xlat_en_i` low, the response address equals the request address, `rsp_hit_o` is 1, `rsp_miss_o` is 0 and `rsp_wimg_o` is 0.
- R2: The upper word holds the effective block base in bits 31:17, the 11-bit length code in bits 12:2, the supervisor enable in bit 1 and the user enable in bit 0. The word is written when `cfg_we_i` and `cfg_sel_hi_i` are both 1, at entry `cfg_idx_i`.
- R3: The lower word holds the physical block base in bits 31:17 and the attributes in bits 6:3. It is written when `cfg_we_i` is 1 and `cfg_sel_hi_i` is 0. Bits 1:0 (protection) do not change the resulting address or attributes.
- R4: The compare mask has bits 31:28 set, the inverse of the length code in bits 27:17, and bits 16:0 clear. An entry matches when the address ANDed with the mask equals its effective base followed by 17 zero bits.
- R5: On a match, the response address is (address AND NOT mask) OR (physical base AND mask), and `rsp_wimg_o` carries the entry's attributes.
- R6: When several entries match, the one with the lowest index supplies the result. Index 7 takes part like any other index.
- R7: The privilege bit `priv_user_i` is 0 for supervisor and 1 for user. An entry takes part in a supervisor access only if its bit 1 is set, and in a user access only if its bit 0 is set.
- R8: With translation enabled and no entry matching, `rsp_miss_o` is 1, `rsp_hit_o` is 0, the response address equals the request address and `rsp_wimg_o` is 0.
- R9: The outputs are registered. `rsp_vld_o` follows `req_vld_i` by one cycle. When there was no request in the previous cycle, `rsp_hit_o` and `rsp_miss_o` are both 0.
- R10: Reset clears all entries (both enables 0) and all outputs. After reset, an enabled lookup misses.
- R11: A write applies to lookups presented in the cycle after the write. A lookup presented in the same cycle as the write sees the old contents.
- R12: `rsp_hit_o` and `rsp_miss_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Entry word write strobe |
| cfg_sel_hi_i | input | 1 | 1 selects the upper word, 0 the lower word |
| cfg_idx_i | input | 3 | Entry index to write |
| cfg_wdata_i | input | 32 | Word to write |
| req_vld_i | input | 1 | Lookup strobe |
| req_addr_i | input | 32 | Effective address |
| xlat_en_i | input | 1 | Data translation enable |
| priv_user_i | input | 1 | 1 for user mode, 0 for supervisor |
| rsp_vld_o | output | 1 | Response valid |
| rsp_addr_o | output | 32 | Physical address |
| rsp_hit_o | output | 1 | Block translation produced the address |
| rsp_miss_o | output | 1 | No entry matched; page-table stage takes over |
| rsp_wimg_o | output | 4 | Cache attributes of the winning entry |

## Verification
The hardest case to reach from the ports is an address that matches more than one entry, where the outcome depends on both index priority and the privilege bit. The entry set therefore contains three entries over the same region at indices 0, 2 and 3. They have different enables and block sizes, so the same address resolves to a different winner in each mode, and addresses just inside and just outside the larger block check the edge of the mask. The lookup that races a write is reached by pulsing the write and the request on the same edge, then repeating the request on the next edge.

// File: rtl/blk_xlat_pkg.sv
package blk_xlat_pkg;
  localparam int unsigned AW     = 32;
  localparam int unsigned BLK_LO = 17;
  localparam int unsigned BASE_W = AW - BLK_LO;
  localparam int unsigned LEN_W  = 11;

  typedef struct packed {
    logic [BASE_W-1:0] ebase;
    logic [3:0]        rsv;
    logic [LEN_W-1:0]  blen;
    logic              sv;
    logic              uv;
  } ent_hi_t;

  typedef struct packed {
    logic [BASE_W-1:0] pbase;
    logic [9:0]        rsv;
    logic [3:0]        wimg;
    logic              rsv2;
    logic [1:0]        pp;
  } ent_lo_t;
endpackage

// File: rtl/blk_xlat_regs.sv
module blk_xlat_regs
  import blk_xlat_pkg::*;
#(
  parameter int unsigned N_ENT = 8,
  localparam int unsigned IDX_W = $clog2(N_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             sel_hi_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [AW-1:0]    wdata_i,
  output ent_hi_t          hi_o [N_ENT],
  output ent_lo_t          lo_o [N_ENT]
);
  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_o[i] <= '0;
        lo_o[i] <= '0;
      end else if (we_i && idx_i == IDX_W'(i)) begin
        if (sel_hi_i) hi_o[i] <= ent_hi_t'(wdata_i);
        else          lo_o[i] <= ent_lo_t'(wdata_i);
      end
    end
  end

  AST_WR_HI_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && sel_hi_i |=> hi_o[$past(idx_i)] == ent_hi_t'($past(wdata_i))); // R11
  AST_WR_LO_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !sel_hi_i |=> lo_o[$past(idx_i)] == ent_lo_t'($past(wdata_i))); // R11
endmodule

// File: rtl/blk_xlat_match.sv
module blk_xlat_match
  import blk_xlat_pkg::*;
(
  input  ent_hi_t       hi_i,
  input  ent_lo_t       lo_i,
  input  logic [AW-1:0] addr_i,
  input  logic          user_i,
  output logic          match_o,
  output logic [AW-1:0] paddr_o,
  output logic [3:0]    wimg_o
);
  logic [AW-1:0] mask;
  logic          en;

  assign mask    = {4'hF, ~hi_i.blen, {BLK_LO{1'b0}}};
  assign en      = user_i ? hi_i.uv : hi_i.sv;
  assign match_o = en && ((addr_i & mask) == {hi_i.ebase, {BLK_LO{1'b0}}});
  assign paddr_o = (addr_i & ~mask) | ({lo_i.pbase, {BLK_LO{1'b0}}} & mask);
  assign wimg_o  = lo_i.wimg;
endmodule

// File: rtl/blk_xlat_prio.sv
module blk_xlat_prio #(
  parameter int unsigned N_ENT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_ENT-1:0] match_i,
  output logic [N_ENT-1:0] grant_o,
  output logic             any_o
);
  always_comb begin
    grant_o = '0;
    for (int i = N_ENT - 1; i >= 0; i--)
      if (match_i[i]) grant_o = N_ENT'(1) << i;
  end
  assign any_o = |match_i;

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o)); // R6
  AST_GRANT_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i[0] |-> grant_o[0]); // R6
  AST_GRANT_PRESENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> (grant_o & match_i) != '0); // R6
endmodule

// File: rtl/blk_xlat_unit.sv
module blk_xlat_unit
  import blk_xlat_pkg::*;
#(
  parameter int unsigned N_ENT = 8,
  localparam int unsigned IDX_W = $clog2(N_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_sel_hi_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic [31:0]      cfg_wdata_i,
  input  logic             req_vld_i,
  input  logic [31:0]      req_addr_i,
  input  logic             xlat_en_i,
  input  logic             priv_user_i,
  output logic             rsp_vld_o,
  output logic [31:0]      rsp_addr_o,
  output logic             rsp_hit_o,
  output logic             rsp_miss_o,
  output logic [3:0]       rsp_wimg_o
);
  ent_hi_t          hi_q [N_ENT];
  ent_lo_t          lo_q [N_ENT];
  logic [N_ENT-1:0] match, grant;
  logic             any;
  logic [AW-1:0]    paddr [N_ENT];
  logic [3:0]       wimg  [N_ENT];
  logic [AW-1:0]    sel_addr;
  logic [3:0]       sel_wimg;

  blk_xlat_regs #(.N_ENT(N_ENT)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_hi_i(cfg_sel_hi_i), .idx_i(cfg_idx_i),
    .wdata_i(cfg_wdata_i), .hi_o(hi_q), .lo_o(lo_q)
  );

  for (genvar i = 0; i < N_ENT; i++) begin : g_match
    blk_xlat_match u_match (
      .hi_i(hi_q[i]), .lo_i(lo_q[i]), .addr_i(req_addr_i), .user_i(priv_user_i),
      .match_o(match[i]), .paddr_o(paddr[i]), .wimg_o(wimg[i])
    );
  end

  blk_xlat_prio #(.N_ENT(N_ENT)) u_prio (
    .clk_i, .rst_ni, .match_i(match), .grant_o(grant), .any_o(any)
  );

  always_comb begin
    sel_addr = '0;
    sel_wimg = '0;
    for (int i = 0; i < N_ENT; i++) begin
      sel_addr |= paddr[i] & {AW{grant[i]}};
      sel_wimg |= wimg[i] & {4{grant[i]}};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_vld_o  <= 1'b0;
      rsp_addr_o <= '0;
      rsp_hit_o  <= 1'b0;
      rsp_miss_o <= 1'b0;
      rsp_wimg_o <= '0;
    end else begin
      rsp_vld_o  <= req_vld_i;
      rsp_hit_o  <= 1'b0;
      rsp_miss_o <= 1'b0;
      if (req_vld_i) begin
        if (!xlat_en_i) begin
          rsp_addr_o <= req_addr_i;
          rsp_hit_o  <= 1'b1;
          rsp_wimg_o <= '0;
        end else if (any) begin
          rsp_addr_o <= sel_addr;
          rsp_hit_o  <= 1'b1;
          rsp_wimg_o <= sel_wimg;
        end else begin
          rsp_addr_o <= req_addr_i;
          rsp_miss_o <= 1'b1;
          rsp_wimg_o <= '0;
        end
      end
    end
  end

  AST_OFF_PASSTHRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_vld_i && !xlat_en_i |=> rsp_hit_o && !rsp_miss_o && rsp_addr_o == $past(req_addr_i)); // R1
  AST_MISS_PASSTHRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_vld_i && xlat_en_i && match == '0 |=> rsp_miss_o && rsp_addr_o == $past(req_addr_i) && rsp_wimg_o == '0); // R8
  AST_RSP_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_vld_i |=> rsp_vld_o); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_vld_i |=> !rsp_hit_o && !rsp_miss_o); // R9
  AST_HIT_MISS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_hit_o && rsp_miss_o)); // R12
endmodule

// File: tb/blk_xlat_unit_tb_top.sv
module blk_xlat_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0, cfg_sel_hi_i = 1'b0;
  logic [2:0]  cfg_idx_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        req_vld_i = 1'b0, xlat_en_i = 1'b0, priv_user_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        rsp_vld_o, rsp_hit_o, rsp_miss_o;
  logic [31:0] rsp_addr_o;
  logic [3:0]  rsp_wimg_o;

  int n_chk = 0, n_bad = 0;

  always #2 clk_i = ~clk_i;

  blk_xlat_unit dut_i (.*);

  typedef struct packed {
    logic        en;
    logic        usr;
    logic [31:0] addr;
    logic [31:0] x_addr;
    logic        x_hit;
    logic        x_miss;
    logic [3:0]  x_wimg;
  } vec_t;

  // en, usr, addr, expected addr, hit, miss, wimg
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 32'h1234_5678, 32'h1234_5678, 1'b1, 1'b0, 4'h0}, // R1
    '{1'b1, 1'b0, 32'h8000_1234, 32'h0012_1234, 1'b1, 1'b0, 4'h5}, // R5 entry0
    '{1'b1, 1'b1, 32'h8000_1234, 32'h2000_1234, 1'b1, 1'b0, 4'h3}, // R7 entry2
    '{1'b1, 1'b0, 32'h8005_4321, 32'h3005_4321, 1'b1, 1'b0, 4'hF}, // R4 entry3
    '{1'b1, 1'b1, 32'h8005_4321, 32'h2005_4321, 1'b1, 1'b0, 4'h3}, // R6 entry2 over 3
    '{1'b1, 1'b0, 32'h9ABC_DEF0, 32'h1ABC_DEF0, 1'b1, 1'b0, 4'h8}, // R4 nibble only
    '{1'b1, 1'b1, 32'h9ABC_DEF0, 32'h1ABC_DEF0, 1'b1, 1'b0, 4'h8}, // R7
    '{1'b1, 1'b1, 32'hA001_0000, 32'h4401_0000, 1'b1, 1'b0, 4'h1}, // R6 entry7
    '{1'b1, 1'b0, 32'hA001_0000, 32'hA001_0000, 1'b0, 1'b1, 4'h0}, // R7 R8
    '{1'b1, 1'b0, 32'h8020_0000, 32'h8020_0000, 1'b0, 1'b1, 4'h0}, // R4 just past
    '{1'b1, 1'b0, 32'h801F_FFFC, 32'h301F_FFFC, 1'b1, 1'b0, 4'hF}, // R4 last word
    '{1'b0, 1'b1, 32'hA001_0000, 32'hA001_0000, 1'b1, 1'b0, 4'h0}, // R1
    '{1'b1, 1'b0, 32'h1000_0000, 32'h1000_0000, 1'b0, 1'b1, 4'h0}  // R8
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic hi, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_hi_i = hi; cfg_idx_i = idx; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic lookup(input logic en, input logic usr, input logic [31:0] a);
    @(negedge clk_i);
    req_vld_i = 1'b1; xlat_en_i = en; priv_user_i = usr; req_addr_i = a;
    @(negedge clk_i);
    req_vld_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R10 vld", 32'(rsp_vld_o), 0);
    chk("R10 hit", 32'(rsp_hit_o), 0);
    chk("R10 miss", 32'(rsp_miss_o), 0);
    chk("R10 addr", rsp_addr_o, 0);
    rst_ni = 1'b1;
    lookup(1'b1, 1'b0, 32'h0000_0040);
    chk("R10 empty miss", 32'(rsp_miss_o), 1);
    chk("R10 empty addr", rsp_addr_o, 32'h0000_0040);

    // R2 R3 entry setup
    wr(3'd0, 1'b1, 32'h8000_0002); wr(3'd0, 1'b0, 32'h0012_002A);
    wr(3'd1, 1'b1, 32'h9000_1FFF); wr(3'd1, 1'b0, 32'h1000_0040);
    wr(3'd2, 1'b1, 32'h8000_003D); wr(3'd2, 1'b0, 32'h2000_0018);
    wr(3'd3, 1'b1, 32'h8000_003F); wr(3'd3, 1'b0, 32'h3000_0078);
    wr(3'd7, 1'b1, 32'hA000_0001); wr(3'd7, 1'b0, 32'h4400_0008);

    for (int i = 0; i < NV; i++) begin
      lookup(VECS[i].en, VECS[i].usr, VECS[i].addr);
      chk($sformatf("R5 vec%0d addr", i), rsp_addr_o, VECS[i].x_addr);
      chk($sformatf("R8 vec%0d hit", i), 32'(rsp_hit_o), 32'(VECS[i].x_hit));
      chk($sformatf("R8 vec%0d miss", i), 32'(rsp_miss_o), 32'(VECS[i].x_miss));
      chk($sformatf("R5 vec%0d wimg", i), 32'(rsp_wimg_o), 32'(VECS[i].x_wimg));
      chk($sformatf("R12 vec%0d excl", i), 32'(rsp_hit_o & rsp_miss_o), 0);
      chk($sformatf("R9 vec%0d vld", i), 32'(rsp_vld_o), 1);
    end

    // R9 idle cycle after a request
    @(negedge clk_i);
    chk("R9 idle vld", 32'(rsp_vld_o), 0);
    chk("R9 idle hit", 32'(rsp_hit_o | rsp_miss_o), 0);

    // R11 write and lookup on the same edge, then again
    wr(3'd4, 1'b0, 32'h5500_0003); // R3 protection bits set
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_hi_i = 1'b1; cfg_idx_i = 3'd4; cfg_wdata_i = 32'hB000_0002;
    req_vld_i = 1'b1; xlat_en_i = 1'b1; priv_user_i = 1'b0; req_addr_i = 32'hB000_0010;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    chk("R11 same-cycle miss", 32'(rsp_miss_o), 1);
    @(negedge clk_i);
    req_vld_i = 1'b0;
    chk("R11 next-cycle hit", 32'(rsp_hit_o), 1);
    chk("R3 pp ignored addr", rsp_addr_o, 32'h5500_0010);
    chk("R3 pp ignored wimg", 32'(rsp_wimg_o), 0);

    // R2 clearing the supervisor enable disables the entry
    wr(3'd4, 1'b1, 32'hB000_0000);
    lookup(1'b1, 1'b0, 32'hB000_0010);
    chk("R2 enable cleared", 32'(rsp_miss_o), 1);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule